// File: doc/BRIEF.md
# Interrupt Level Concentrator Bridge

This block sits between a peripheral module bus carrying 32 level-sensitive interrupt request lines and a system interrupt controller that accepts only 8 request levels. Requests on the seven lowest levels reach the controller unchanged, each on its own output line. All of the remaining levels are merged onto the top output level. A separate enable decides whether that merged group may request at all.

Because the merged output hides which of the upper levels is requesting, the block keeps a 32-bit pending image of all request lines. A handler reads this image through a small register read port to find the exact source. The pending image follows the live request lines, so no software clear is needed. A bit drops as soon as its source deasserts.

Top module: `irq_level_concentrator`

## Requirements
- R1: Output levels 0..6 equal request inputs 0..6 as sampled on the previous rising clock edge (one clock of latency).
- R2: Output level 7 is 1 one clock after any of request inputs 7..31 is 1 while the upper enable is 1.
- R3: While the upper enable is 0, output level 7 is 0 whatever request inputs 7..31 carry, and those requests still appear in the pending image.
- R4: The pending image bit i equals request input i as sampled on the previous rising edge, so a bit clears one clock after its source deasserts.
- R5: A read with address 0 returns the full 32-bit pending image on rd_data, with rd_valid at 1, in the cycle after rd_en was sampled at 1.
- R6: A read with any nonzero address returns rd_data equal to 0, with rd_valid at 1, in the cycle after rd_en was sampled at 1.
- R7: During and right after reset, irq_out, rd_data and rd_valid are 0 and the pending image reads back as 0.
- R8: In a cycle after rd_en was sampled at 0, rd_valid is 0 and rd_data is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_in | input | 32 | Level-sensitive peripheral requests, bit i is level i |
| upper_en | input | 1 | Lets levels 7..31 drive output level 7 |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Read word address, 0 selects the pending image |
| irq_out | output | 8 | Request levels to the system interrupt controller |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one clock after rd_en |

## Verification
The hardest case to reach from the ports is an upper-level request that is present in the pending image while the merged output stays low. This happens only when the upper enable is cleared during the request. It is also the case where a handler could miss a source. The stimulus walks a single set bit across all 32 levels twice, once with the enable at 0 and once at 1. Each step ends in a pending read, so every level is seen both at irq_out and in the read-back image. Random multi-bit patterns, a clear-after-set step and reads at every nonzero address cover merging, follow-the-source clearing and address decoding.

// File: rtl/irq_cc_pkg.sv
package irq_cc_pkg;
    localparam int unsigned IN_LEVELS  = 32;
    localparam int unsigned OUT_LEVELS = 8;
    localparam int unsigned RD_AW      = 4;
    localparam int unsigned PEND_WORD  = 0;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_PEND = 2'd1,
        RD_NONE = 2'd2
    } rd_kind_e;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
    parameter int unsigned N_IN = irq_cc_pkg::IN_LEVELS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] req_in,
    output logic [N_IN-1:0] pend_q
);
    // Each bit tracks its live request line, one clock late.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= req_in;
    end
endmodule

// File: rtl/irq_level_fold.sv
module irq_level_fold #(
    parameter int unsigned N_IN  = irq_cc_pkg::IN_LEVELS,
    parameter int unsigned N_OUT = irq_cc_pkg::OUT_LEVELS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  req_in,
    input  logic             upper_en,
    output logic [N_OUT-1:0] irq_q
);
    localparam int unsigned DIRECT = N_OUT - 1;

    logic [N_OUT-1:0] irq_d;

    genvar g;
    generate
        for (g = 0; g < DIRECT; g++) begin : g_direct
            assign irq_d[g] = req_in[g];
        end
    endgenerate

    // The shared top level carries the OR of every remaining input.
    assign irq_d[DIRECT] = upper_en & (|req_in[N_IN-1:DIRECT]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port #(
    parameter int unsigned DW = irq_cc_pkg::IN_LEVELS,
    parameter int unsigned AW = irq_cc_pkg::RD_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] pend_q,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    import irq_cc_pkg::*;

    localparam logic [AW-1:0] PEND_A = AW'(PEND_WORD);

    rd_kind_e kind;

    always_comb begin
        if (!rd_en)                kind = RD_IDLE;
        else if (rd_addr == PEND_A) kind = RD_PEND;
        else                       kind = RD_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            unique case (kind)
                RD_PEND: begin
                    rd_data  <= pend_q;
                    rd_valid <= 1'b1;
                end
                RD_NONE: begin
                    rd_data  <= '0;
                    rd_valid <= 1'b1;
                end
                default: begin
                    rd_data  <= '0;
                    rd_valid <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/irq_level_concentrator.sv
module irq_level_concentrator #(
    parameter int unsigned N_IN  = irq_cc_pkg::IN_LEVELS,
    parameter int unsigned N_OUT = irq_cc_pkg::OUT_LEVELS,
    parameter int unsigned AW    = irq_cc_pkg::RD_AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  req_in,
    input  logic             upper_en,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [N_OUT-1:0] irq_out,
    output logic [N_IN-1:0]  rd_data,
    output logic             rd_valid
);
    logic [N_IN-1:0] pend_q;

    irq_pend_reg #(.N_IN(N_IN)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_in (req_in),
        .pend_q (pend_q)
    );

    irq_level_fold #(.N_IN(N_IN), .N_OUT(N_OUT)) u_fold (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_in   (req_in),
        .upper_en (upper_en),
        .irq_q    (irq_out)
    );

    irq_read_port #(.DW(N_IN), .AW(AW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .pend_q   (pend_q),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/irq_level_concentrator_chk.sv
module irq_level_concentrator_chk #(
    parameter int unsigned N_IN  = irq_cc_pkg::IN_LEVELS,
    parameter int unsigned N_OUT = irq_cc_pkg::OUT_LEVELS,
    parameter int unsigned AW    = irq_cc_pkg::RD_AW
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_IN-1:0]  req_in,
    input logic             upper_en,
    input logic             rd_en,
    input logic [AW-1:0]    rd_addr,
    input logic [N_OUT-1:0] irq_out,
    input logic [N_IN-1:0]  rd_data,
    input logic             rd_valid,
    input logic [N_IN-1:0]  pend_q
);
    localparam int unsigned DIRECT = N_OUT - 1;

    logic warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm <= 1'b0;
        else        warm <= 1'b1;
    end

    // R1
    low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        irq_out[DIRECT-1:0] == $past(req_in[DIRECT-1:0]));

    // R2
    upper_merge_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        ($past(upper_en) && $past(|req_in[N_IN-1:DIRECT])) |-> irq_out[DIRECT]);

    // R3
    upper_gate_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        !$past(upper_en) |-> !irq_out[DIRECT]);

    // R4
    pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        pend_q == $past(req_in));

    // R5
    rd_pend_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        ($past(rd_en) && $past(rd_addr) == '0) |-> (rd_valid && rd_data == $past(pend_q)));

    // R6
    rd_other_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        ($past(rd_en) && $past(rd_addr) != '0) |-> (rd_valid && rd_data == '0));

    // R8
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        !$past(rd_en) |-> (!rd_valid && rd_data == '0));

    // R7
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |-> (irq_out == '0 && !rd_valid && rd_data == '0 && pend_q == '0));
endmodule

bind irq_level_concentrator irq_level_concentrator_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_in   (req_in),
    .upper_en (upper_en),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .irq_out  (irq_out),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .pend_q   (pend_q)
);

// File: tb/test_irq_level_concentrator.sv
module test_irq_level_concentrator;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req_in = '0;
    logic        upper_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [7:0]  irq_out;
    logic [31:0] rd_data;
    logic        rd_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    irq_level_concentrator i_irq_level_concentrator (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_in   (req_in),
        .upper_en (upper_en),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .irq_out  (irq_out),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fold(input logic [31:0] r, input logic en);
        return {en & (|r[31:7]), r[6:0]};
    endfunction

    // Apply a pattern, check the outputs, then read the pending word.
    task automatic step(input logic [31:0] r, input logic en, input string tag);
        @(negedge clk);
        req_in   = r;
        upper_en = en;
        rd_en    = 1'b0;
        @(negedge clk);
        check({tag, " irq_out"}, {24'd0, irq_out}, {24'd0, fold(r, en)});
        check({tag, " idle rd_valid R8"}, {31'd0, rd_valid}, 32'd0);
        rd_en   = 1'b1;
        rd_addr = 4'd0;
        @(negedge clk);
        check({tag, " pend R4 R5"}, rd_data, r);
        check({tag, " rd_valid R5"}, {31'd0, rd_valid}, 32'd1);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7 irq_out", {24'd0, irq_out}, 32'd0);
        check("R7 rd_valid", {31'd0, rd_valid}, 32'd0);
        check("R7 rd_data", rd_data, 32'd0);
        rst_n = 1'b1;
        rd_en = 1'b1;
        rd_addr = 4'd0;
        @(negedge clk);
        check("R7 pending after reset", rd_data, 32'd0);
        rd_en = 1'b0;

        // R1 R2 R3: walking one over every level, enable both ways
        for (int e = 0; e < 2; e++) begin
            for (int i = 0; i < 32; i++) begin
                step(32'd1 << i, e[0], (i < 7) ? "R1" : (e == 0 ? "R3" : "R2"));
            end
        end

        // R2 R3: random multi-bit patterns
        for (int k = 0; k < 60; k++) begin
            logic [31:0] r;
            r = $urandom;
            step(r, k[0], k[0] ? "R2 rand" : "R3 rand");
        end

        // R4: clears after source drops
        step(32'hFFFF_FFFF, 1'b1, "R4 set");
        step(32'h0000_0000, 1'b1, "R4 clear");

        // R6: nonzero addresses read zero
        for (int a = 1; a < 16; a++) begin
            @(negedge clk);
            req_in  = 32'hA5A5_F0F1;
            rd_en   = 1'b1;
            rd_addr = a[3:0];
            @(negedge clk);
            check("R6 rd_data", rd_data, 32'd0);
            check("R6 rd_valid", {31'd0, rd_valid}, 32'd1);
            rd_en = 1'b0;
        end
        @(negedge clk);
        check("R8 rd_data idle", rd_data, 32'd0);
        check("R8 rd_valid idle", {31'd0, rd_valid}, 32'd0);
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule